// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a successive-approximation analog-to-digital converter. It picks an analog channel out of a group of eight and drives a trial code to the reference ladder. On each step it reads back one comparator bit, working from the most significant bit down. The finished code goes into a result register owned by that channel. The ladder, the comparator and the pin multiplexing stay outside; the comparator reaches the block as a single input bit that is true when the analog input is at or above the trial code.

Software chooses the resolution (8 or 10 bits) and whether the faster sample-and-hold timing is used. These two settings fix the exact number of conversion-clock cycles one channel takes. A conversion is launched by setting the start bit. In trigger mode, setting the start bit instead arms a wait for a falling edge on the trigger pin. A later falling edge during a conversion discards it and starts that channel over. Five operating modes cover a single channel once, a single channel repeatedly, an ascending sweep once, that sweep looped, and a looped sweep in which one priority channel alternates with every other channel.

One conversion clock equals one cycle of `clk`. Configuration inputs are assumed to be held steady while the start bit is set. The trigger pin is assumed to be synchronous to `clk`.

Top module: `sar_seq`

## Requirements
- R1: With `res_hi`=1 the stored code equals the largest 10-bit value whose trial gave `cmp_in`=1 (a bench input value v converts to v). Trials are decided from bit 9 down to bit 0, one bit per cycle.
- R2: With `res_hi`=0 only `dac_code` bits 9..2 are trialled and bits 1..0 stay 0. The resulting 8-bit code lands in `rd_data` bits 7..0 with bits 9..8 reading zero, so input v converts to v/4 rounded down.
- R3: One channel keeps `busy` high for exactly 49 cycles (8-bit, `sh_en`=0), 59 (10-bit, `sh_en`=0), 28 (8-bit, `sh_en`=1) or 33 (10-bit, `sh_en`=1). Each conversion is a sampling phase, the bit steps, and a final store cycle.
- R4: With `ext_trig_en`=0, a `start_set` pulse while idle raises `busy` on the next clock edge. A `start_set` pulse during a conversion has no effect on its length or result.
- R5: With `ext_trig_en`=1, `start_set` only sets `start_bit`, and `busy` stays low until a high-to-low change of `trig_n`. Falling edges while `start_bit` is 0 start nothing.
- R6: In trigger mode, a falling edge of `trig_n` during a conversion restarts that channel from its first sampling cycle. `busy` stays high for a full conversion length from the restart, and nothing is written for the discarded attempt.
- R7: Mode code 0 (one-shot) converts channel `chan_sel` once. It then clears `start_bit` and raises `done`, and `done` is never high together with `busy`.
- R8: Mode code 1 (repeat) converts `chan_sel` back to back, refreshing its result each time, until `start_clr`. `start_clr` drops `busy` and `start_bit` on the next edge and the interrupted conversion writes nothing.
- R9: Mode code 2 (single sweep) converts channels 0 to L-1 in ascending order, where `sweep_len` code k gives L = 2(k+1). It then clears `start_bit` and sets `done`; results of channels L and above are left unchanged.
- R10: Mode code 3 (repeat sweep) loops over channels 0 to L-1 in ascending order without stopping.
- R11: Mode code 4 (priority sweep) loops forever with `chan_sel` as priority channel P, converting P, then the next channel of 0..L-1 other than P in ascending order (wrapping), then P again.
- R12: `rd_data` shows the result register selected by `rd_chan`, and every result register is zero after reset.
- R13: `dac_code` is zero whenever `busy` is low, and `done` is cleared by `start_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_set | input | 1 | Pulse: software writes the start bit to 1 |
| start_clr | input | 1 | Pulse: software writes the start bit to 0 |
| ext_trig_en | input | 1 | 1 selects the external trigger start |
| trig_n | input | 1 | External trigger pin, active on its falling edge |
| mode | input | 3 | Operating mode code (0..4) |
| chan_sel | input | 3 | Channel for modes 0/1, priority channel for mode 4 |
| sweep_len | input | 2 | Sweep length code, L = 2(code+1) |
| res_hi | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| sh_en | input | 1 | 1 = sample-and-hold timing profile |
| cmp_in | input | 1 | Comparator: analog input >= `dac_code` |
| dac_code | output | 10 | Trial code to the reference ladder |
| cur_chan | output | 3 | Channel being converted |
| rd_chan | input | 3 | Result register to read |
| rd_data | output | 10 | Contents of result register `rd_chan` |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Single-run mode finished |
| start_bit | output | 1 | Current state of the start bit |

## Verification
If the cycle counter or phase decode goes wrong, the length of a `busy` run is off from the table and the stored code goes wrong with it. Both show within one conversion. A wrong bit pointer in the successive-approximation register yields a code that differs from the modelled input. That becomes visible at the first read after the store cycle. A bad channel step in the sequencer shows up as a wrong `cur_chan` at the very next conversion boundary. It can also show up as a result written into a channel outside the sweep. Restart and stop errors show up as a `busy` run that is too short or too long, or as a result register changed by an attempt that was discarded.

// File: rtl/sar_pkg.sv
// Shared encodings for the conversion sequencer.
// Assumes mode codes are fixed by software convention (0..4); other codes act as one-shot.
package sar_pkg;

    typedef enum logic [2:0] {
        MODE_ONESHOT = 3'd0,
        MODE_REPEAT  = 3'd1,
        MODE_SWEEP   = 3'd2,
        MODE_RSWEEP  = 3'd3,
        MODE_PRISWP  = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CONV  = 2'd2
    } state_e;

    // True for the modes that keep converting until software stops them.
    function automatic logic mode_loops(input logic [2:0] m);
        return (m == MODE_REPEAT) || (m == MODE_RSWEEP) || (m == MODE_PRISWP);
    endfunction

endpackage

// File: rtl/sar_phase.sv
// Phase decoder: maps the in-conversion cycle count onto sampling, bit-step
// and store phases for the selected resolution and timing profile.
// Assumes every total exceeds the step count by at least two cycles.
module sar_phase #(
    parameter int RES_W   = 10,
    parameter int LO_W    = 8,
    parameter int T_LO    = 49,
    parameter int T_HI    = 59,
    parameter int T_LO_SH = 28,
    parameter int T_HI_SH = 33,
    parameter int CNT_W   = 6,
    parameter int IDX_W   = 4
) (
    input  logic             res_hi,
    input  logic             sh_en,
    input  logic [CNT_W-1:0] cyc,
    output logic             in_sample,
    output logic             in_step,
    output logic             last_cyc,
    output logic [IDX_W-1:0] bit_idx
);

    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] nsteps;
    logic [CNT_W-1:0] samp;
    logic [CNT_W-1:0] offs;

    // Total length and step count for the current configuration.
    always_comb begin
        if (res_hi) begin
            total  = sh_en ? CNT_W'(T_HI_SH) : CNT_W'(T_HI);
            nsteps = CNT_W'(RES_W);
        end else begin
            total  = sh_en ? CNT_W'(T_LO_SH) : CNT_W'(T_LO);
            nsteps = CNT_W'(LO_W);
        end
        samp = total - nsteps - CNT_W'(1);
    end

    // Phase flags and the bit under trial, counted down from the MSB.
    always_comb begin
        in_sample = (cyc < samp);
        in_step   = !in_sample && (cyc < (samp + nsteps));
        last_cyc  = (cyc == (total - CNT_W'(1)));
        offs      = cyc - samp;
        bit_idx   = IDX_W'(RES_W - 1) - IDX_W'(offs);
    end

endmodule

// File: rtl/sar_datapath.sv
// Successive-approximation register: cleared while sampling, then resolves
// one bit per step cycle from the comparator. Drives the trial code only
// during step cycles, zero otherwise.
module sar_datapath #(
    parameter int RES_W = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_sample,
    input  logic             in_step,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] sar_q,
    output logic [RES_W-1:0] dac_code
);

    logic [RES_W-1:0] mask;
    logic [RES_W-1:0] trial;

    // Trial code: bits already decided plus the bit under test.
    always_comb begin
        mask     = RES_W'(1) << bit_idx;
        trial    = sar_q | mask;
        dac_code = in_step ? trial : '0;
    end

    // Register update: clear while sampling, keep or drop the trial bit on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q <= '0;
        end else if (in_sample) begin
            sar_q <= '0;
        end else if (in_step && cmp_in) begin
            sar_q <= trial;
        end
    end

endmodule

// File: rtl/sar_chan_seq.sv
// Channel sequencer: yields the channel for each conversion and flags the
// final one of a single-run sequence. Assumes sweep length never exceeds NCH.
module sar_chan_seq
    import sar_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            advance,
    input  logic [2:0]      mode,
    input  logic [CH_W-1:0] pri_ch,
    input  logic [1:0]      len_code,
    output logic [CH_W-1:0] chan,
    output logic            seq_last
);

    localparam int LW = CH_W + 1;

    logic [LW-1:0]   len;
    logic [CH_W-1:0] pos_q;
    logic [CH_W-1:0] oth_q;
    logic            pri_slot_q;
    logic [CH_W-1:0] first_oth;
    logic [CH_W-1:0] next_oth;
    logic [LW-1:0]   cand_a;
    logic [LW-1:0]   cand_b;

    // Sweep length and next non-priority channel, wrapping inside the sweep.
    always_comb begin
        len       = LW'({len_code, 1'b0}) + LW'(2);
        first_oth = (pri_ch == '0) ? CH_W'(1) : '0;
        cand_a    = LW'(oth_q) + LW'(1);
        if (cand_a >= len) cand_a = '0;
        cand_b = cand_a;
        if (cand_b == LW'(pri_ch)) begin
            cand_b = cand_b + LW'(1);
            if (cand_b >= len) cand_b = '0;
        end
        next_oth = CH_W'(cand_b);
    end

    // Channel and end-of-sequence flag per mode.
    always_comb begin
        case (mode)
            MODE_SWEEP, MODE_RSWEEP: begin
                chan     = pos_q;
                seq_last = (LW'(pos_q) == (len - LW'(1)));
            end
            MODE_PRISWP: begin
                chan     = pri_slot_q ? pri_ch : oth_q;
                seq_last = 1'b0;
            end
            default: begin
                chan     = pri_ch;
                seq_last = 1'b1;
            end
        endcase
    end

    // Position state: loaded at start, stepped after each stored conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            oth_q      <= '0;
            pri_slot_q <= 1'b1;
        end else if (init) begin
            pos_q      <= '0;
            oth_q      <= first_oth;
            pri_slot_q <= 1'b1;
        end else if (advance) begin
            pos_q <= seq_last ? '0 : pos_q + CH_W'(1);
            if (pri_slot_q) begin
                pri_slot_q <= 1'b0;
            end else begin
                pri_slot_q <= 1'b1;
                oth_q      <= next_oth;
            end
        end
    end

endmodule

// File: rtl/sar_result_bank.sv
// One result register per channel, written at the store cycle, read by index.
module sar_result_bank #(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CH_W-1:0]  wchan,
    input  logic [RES_W-1:0] wdata,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [RES_W-1:0] rd_data
);

    logic [RES_W-1:0] bank [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_reg
        logic [RES_W-1:0] q;
        // Holds channel g's last finished code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (wchan == CH_W'(g))) begin
                q <= wdata;
            end
        end
        assign bank[g] = q;
    end

    // Read port.
    assign rd_data = bank[rd_chan];

endmodule

// File: rtl/sar_seq.sv
// Top of the conversion sequencer: start/trigger control, per-conversion
// cycle counter, and wiring of phase decoder, SAR datapath, channel
// sequencer and result bank. Assumes configuration is steady while the
// start bit is set and trig_n is synchronous to clk. T_HI is the largest total.
module sar_seq
    import sar_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int RES_W   = 10,
    parameter int LO_W    = 8,
    parameter int T_LO    = 49,
    parameter int T_HI    = 59,
    parameter int T_LO_SH = 28,
    parameter int T_HI_SH = 33
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_set,
    input  logic                     start_clr,
    input  logic                     ext_trig_en,
    input  logic                     trig_n,
    input  logic [2:0]               mode,
    input  logic [$clog2(NCH)-1:0]   chan_sel,
    input  logic [1:0]               sweep_len,
    input  logic                     res_hi,
    input  logic                     sh_en,
    input  logic                     cmp_in,
    output logic [RES_W-1:0]         dac_code,
    output logic [$clog2(NCH)-1:0]   cur_chan,
    input  logic [$clog2(NCH)-1:0]   rd_chan,
    output logic [RES_W-1:0]         rd_data,
    output logic                     busy,
    output logic                     done,
    output logic                     start_bit
);

    localparam int CH_W  = $clog2(NCH);
    localparam int CNT_W = $clog2(T_HI + 1);
    localparam int IDX_W = $clog2(RES_W);

    state_e           state_q;
    logic [CNT_W-1:0] cyc_q;
    logic             trig_q;
    logic             fall;
    logic             in_sample;
    logic             in_step;
    logic             last_cyc;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] wdata;
    logic             seq_init;
    logic             seq_adv;
    logic             seq_last;
    logic             retrig;
    logic             we;

    // Control decodes: trigger edge, restart, store and channel stepping.
    always_comb begin
        fall     = trig_q && !trig_n;
        busy     = (state_q == ST_CONV);
        retrig   = busy && ext_trig_en && fall;
        we       = busy && last_cyc && !start_clr && !retrig;
        seq_init = ((state_q == ST_IDLE) && start_set) ||
                   ((state_q == ST_ARMED) && fall && !start_clr);
        seq_adv  = we;
        wdata    = res_hi ? sar_q : RES_W'(sar_q[RES_W-1 -: LO_W]);
    end

    // Trigger pin history for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b1;
        else        trig_q <= trig_n;
    end

    // Start bit, done flag, state and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cyc_q     <= '0;
            start_bit <= 1'b0;
            done      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cyc_q <= '0;
                    if (start_set) begin
                        start_bit <= 1'b1;
                        done      <= 1'b0;
                        state_q   <= ext_trig_en ? ST_ARMED : ST_CONV;
                    end
                end
                ST_ARMED: begin
                    cyc_q <= '0;
                    if (start_clr) begin
                        start_bit <= 1'b0;
                        state_q   <= ST_IDLE;
                    end else if (fall) begin
                        state_q <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (start_clr) begin
                        start_bit <= 1'b0;
                        cyc_q     <= '0;
                        state_q   <= ST_IDLE;
                    end else if (retrig) begin
                        cyc_q <= '0;
                    end else if (last_cyc) begin
                        cyc_q <= '0;
                        if (seq_last && !mode_loops(mode)) begin
                            start_bit <= 1'b0;
                            done      <= 1'b1;
                            state_q   <= ST_IDLE;
                        end
                    end else begin
                        cyc_q <= cyc_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    sar_phase #(
        .RES_W(RES_W), .LO_W(LO_W), .T_LO(T_LO), .T_HI(T_HI),
        .T_LO_SH(T_LO_SH), .T_HI_SH(T_HI_SH), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_phase (
        .res_hi   (res_hi),
        .sh_en    (sh_en),
        .cyc      (cyc_q),
        .in_sample(in_sample),
        .in_step  (in_step),
        .last_cyc (last_cyc),
        .bit_idx  (bit_idx)
    );

    sar_datapath #(.RES_W(RES_W), .IDX_W(IDX_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_sample(in_sample),
        .in_step  (in_step && busy),
        .bit_idx  (bit_idx),
        .cmp_in   (cmp_in),
        .sar_q    (sar_q),
        .dac_code (dac_code)
    );

    sar_chan_seq #(.NCH(NCH), .CH_W(CH_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (seq_init),
        .advance (seq_adv),
        .mode    (mode),
        .pri_ch  (chan_sel),
        .len_code(sweep_len),
        .chan    (cur_chan),
        .seq_last(seq_last)
    );

    sar_result_bank #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .wchan  (cur_chan),
        .wdata  (wdata),
        .rd_chan(rd_chan),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/sar_seq_chk.sv
// Port-level property checker for sar_seq, attached with bind below.
module sar_seq_chk #(
    parameter int RES_W = 10,
    parameter int LO_W  = 8,
    parameter int CH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             start_bit,
    input logic             res_hi,
    input logic [2:0]       mode,
    input logic [CH_W-1:0]  chan_sel,
    input logic [CH_W-1:0]  cur_chan,
    input logic [RES_W-1:0] dac_code
);

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> start_bit); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!start_bit && $past(busy))); // R7

    AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0)); // R13

    AST_LOW_RES_LSBS: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hi |-> (dac_code[RES_W-LO_W-1:0] == '0)); // R2

    AST_FIXED_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mode == 3'd0 || mode == 3'd1)) |-> (cur_chan == chan_sel)); // R7

endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .LO_W(LO_W), .CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .start_bit(start_bit),
    .res_hi   (res_hi),
    .mode     (mode),
    .chan_sel (chan_sel),
    .cur_chan (cur_chan),
    .dac_code (dac_code)
);

// File: tb/tb_sar_seq.sv
`timescale 1ns/1ps
module tb_sar_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_set, start_clr, ext_trig_en, trig_n;
    logic [2:0] mode, chan_sel, cur_chan, rd_chan;
    logic [1:0] sweep_len;
    logic       res_hi, sh_en, cmp_in;
    logic [9:0] dac_code, rd_data;
    logic       busy, done, start_bit;
    logic [9:0] vin [0:7];
    int         model [0:7];
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    // Comparator model: analog level at or above the trial code.
    assign cmp_in = (vin[cur_chan] >= dac_code);

    sar_seq dut (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .start_clr(start_clr),
        .ext_trig_en(ext_trig_en), .trig_n(trig_n), .mode(mode), .chan_sel(chan_sel),
        .sweep_len(sweep_len), .res_hi(res_hi), .sh_en(sh_en), .cmp_in(cmp_in),
        .dac_code(dac_code), .cur_chan(cur_chan), .rd_chan(rd_chan), .rd_data(rd_data),
        .busy(busy), .done(done), .start_bit(start_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int conv_len(input bit hi, input bit sh);
        if (hi) return sh ? 33 : 59;
        return sh ? 28 : 49;
    endfunction

    function automatic int code_of(input int v, input bit hi);
        return hi ? v : (v >> 2);
    endfunction

    task automatic sw_start();
        @(negedge clk); start_set = 1'b1;
        @(negedge clk); start_set = 1'b0;
    endtask

    task automatic sw_stop();
        @(negedge clk); start_clr = 1'b1;
        @(negedge clk); start_clr = 1'b0;
    endtask

    task automatic read_ch(input int c, output int v);
        rd_chan = 3'(c);
        #1 v = int'(rd_data);
    endtask

    // Counts busy samples from the current negedge; optionally pulses start_set.
    task automatic count_busy(input int inj, output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            start_set = (n == inj);
            @(negedge clk);
        end
        start_set = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n, v, t, cnt;
        int oth [0:7];
        start_set = 0; start_clr = 0; ext_trig_en = 0; trig_n = 1;
        mode = 0; chan_sel = 0; sweep_len = 0; res_hi = 1; sh_en = 0; rd_chan = 0;
        for (int c = 0; c < 8; c++) begin vin[c] = '0; model[c] = 0; end
        rst_n = 0;
        repeat (4) @(negedge clk);
        chk("R7 reset busy", int'(busy), 0);
        chk("R7 reset done", int'(done), 0);
        chk("R8 reset start_bit", int'(start_bit), 0);
        chk("R13 reset dac", int'(dac_code), 0);
        read_ch(3, v); chk("R12 reset result", v, 0);
        rst_n = 1;
        @(negedge clk);

        // One-shot over every channel for all four timing/resolution profiles.
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                mode = 0; chan_sel = 3'(c); res_hi = k[1]; sh_en = k[0];
                vin[c] = 10'((c * 293 + k * 97 + 11) % 1024);
                if (k == 0 && c == 0) vin[c] = 10'd0;
                if (k == 0 && c == 7) vin[c] = 10'd1023;
                if (k == 2 && c == 5) vin[c] = 10'd3;
                sw_start();
                chk("R13 done cleared by start", int'(done), 0);
                chk("R4 busy after start", int'(busy), 1);
                count_busy((k == 2 && c == 4) ? 6 : 0, n);
                t = conv_len(k[1], k[0]);
                chk("R3 conversion length", n, t);
                chk("R7 done raised", int'(done), 1);
                chk("R7 start bit cleared", int'(start_bit), 0);
                chk("R13 dac idle", int'(dac_code), 0);
                model[c] = code_of(int'(vin[c]), k[1]);
                read_ch(c, v);
                chk(k[1] ? "R1 code" : "R2 code", v, model[c]);
                if (!k[1]) chk("R2 upper bits zero", v >> 8, 0);
            end
        end

        // Single sweeps of every length; channels past the sweep keep their value.
        for (int lc = 0; lc < 4; lc++) begin
            @(negedge clk);
            mode = 2; sweep_len = 2'(lc); res_hi = 1; sh_en = 1;
            for (int c = 0; c < 8; c++) vin[c] = 10'((c * 151 + lc * 401 + 7) % 1024);
            sw_start();
            count_busy(0, n);
            chk("R9 sweep length", n, 2 * (lc + 1) * 33);
            chk("R9 sweep done", int'(done), 1);
            chk("R9 sweep start bit", int'(start_bit), 0);
            for (int c = 0; c < 8; c++) begin
                if (c < 2 * (lc + 1)) model[c] = int'(vin[c]);
                read_ch(c, v);
                chk("R9 sweep result", v, model[c]);
            end
        end

        // Repeat on one channel, then stop mid-conversion.
        @(negedge clk);
        mode = 1; chan_sel = 3'd5; res_hi = 0; sh_en = 1; vin[5] = 10'd600;
        t = 28;
        sw_start();
        cnt = 0;
        for (int i = 1; i < 5 * t + 10; i++) begin
            if (!busy) cnt++;
            if (i == 3 * t) begin
                read_ch(5, v); chk("R8 repeat result", v, 150);
                vin[5] = 10'd1000;
            end
            @(negedge clk);
        end
        chk("R8 repeat stays busy", cnt, 0);
        read_ch(5, v); chk("R8 repeat refreshed", v, 250);
        vin[5] = 10'd4;
        sw_stop();
        chk("R8 stop busy", int'(busy), 0);
        chk("R8 stop start bit", int'(start_bit), 0);
        chk("R8 stop no done", int'(done), 0);
        repeat (t + 2) @(negedge clk);
        read_ch(5, v); chk("R8 no write after stop", v, 250);

        // Repeat sweep over two channels.
        @(negedge clk);
        mode = 3; sweep_len = 0; res_hi = 0; sh_en = 1;
        vin[0] = 10'd300; vin[1] = 10'd700;
        sw_start();
        for (int j = 0; j < 6; j++) begin
            chk("R10 channel order", int'(cur_chan), j % 2);
            repeat (t) @(negedge clk);
        end
        sw_stop();
        read_ch(0, v); chk("R10 result ch0", v, 75);
        read_ch(1, v); chk("R10 result ch1", v, 175);

        // Priority sweep: two configurations.
        for (int pc = 0; pc < 2; pc++) begin
            @(negedge clk);
            mode = 4;
            sweep_len = (pc == 0) ? 2'd1 : 2'd0;
            chan_sel  = (pc == 0) ? 3'd2 : 3'd0;
            cnt = 0;
            for (int c = 0; c < 2 * (int'(sweep_len) + 1); c++)
                if (c != int'(chan_sel)) begin oth[cnt] = c; cnt++; end
            sw_start();
            for (int j = 0; j < 10; j++) begin
                chk("R11 priority order", int'(cur_chan),
                    (j % 2 == 0) ? int'(chan_sel) : oth[(j / 2) % cnt]);
                repeat (t) @(negedge clk);
            end
            sw_stop();
        end

        // External trigger: edges before the start bit start nothing.
        @(negedge clk);
        mode = 0; ext_trig_en = 1; chan_sel = 3'd6; res_hi = 1; sh_en = 0;
        vin[6] = 10'd517;
        trig_n = 0; @(negedge clk); trig_n = 1;
        repeat (3) @(negedge clk);
        chk("R5 edge before start ignored", int'(busy), 0);
        chk("R5 start bit still clear", int'(start_bit), 0);
        sw_start();
        chk("R5 armed not busy", int'(busy), 0);
        chk("R5 armed start bit", int'(start_bit), 1);
        repeat (10) @(negedge clk);
        chk("R5 waits for edge", int'(busy), 0);
        trig_n = 0;
        @(negedge clk);
        count_busy(0, n);
        chk("R5 triggered length", n, 59);
        read_ch(6, v); chk("R5 triggered result", v, 517);
        chk("R5 triggered done", int'(done), 1);

        // Retrigger during the bit steps restarts the conversion.
        trig_n = 1;
        @(negedge clk);
        sh_en = 1; vin[6] = 10'd111;
        sw_start();
        trig_n = 0;
        @(negedge clk);
        cnt = 0;
        for (int i = 1; i <= 25; i++) begin
            if (!busy) cnt++;
            if (i == 25) begin vin[6] = 10'd888; trig_n = 1; end
            @(negedge clk);
        end
        chk("R6 busy before retrigger", cnt, 0);
        read_ch(6, v); chk("R6 no partial write", v, 517);
        trig_n = 0;
        count_busy(0, n);
        chk("R6 restarted length", 25 + n, 26 + 33);
        read_ch(6, v); chk("R6 restarted result", v, 888);
        ext_trig_en = 0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule